// File: doc/BRIEF.md
# Bank Lock Timeout Watchdog

This block sits beside one memory bank and watches the bus commands decoded for it. A read-with-lock command addressed to the bank marks the bank as held and starts a cycle timer. The bank stays held until the paired write-with-unlock command arrives. While the bank is held, the bank-available output is low, so other requesters stay off the bank during the read-modify-write sequence.

If the unlock does not arrive within a parameterised number of cycles, the watchdog releases the bank by raising bank-available, so that a lost unlock cannot stall the bus. It also records the event in a sticky hard-error flag. Software clears the flag by writing a one to it. A configuration input can suppress the flag. The bank is still released when the flag is suppressed.

Top module: `bank_lock_watchdog`

## Requirements
- R1: After reset, and after any reset that arrives while the bank is held, `bank_avail` is 1 and `lock_err` is 0.
- R2: A read-with-lock command on an idle or released bank lowers `bank_avail` at the next clock edge. The command is `cmd_valid`=1, `cmd_code`=3'b101 and `cmd_bank`=BANK_ID.
- R3: While the bank is held, a write-with-unlock command raises `bank_avail` at the next clock edge and leaves `lock_err` unchanged. The command is `cmd_valid`=1, `cmd_code`=3'b110 and `cmd_bank`=BANK_ID. This holds for any unlock sampled at edges 1 to LIMIT after the lock edge, and an unlock at edge LIMIT still counts as in time.
- R4: If no unlock has been sampled by edge LIMIT after the lock edge, `bank_avail` rises at that edge and `lock_err` sets at the same edge. `bank_avail` stays low at every earlier edge.
- R5: When `cfg_lock_to_dis` is 1 at the expiry edge, the bank is still released but `lock_err` does not set.
- R6: `lock_err` is write-1-clear. It is cleared when `err_clr_we`=1 and `err_clr_bit`=1. With `err_clr_bit`=0 the write has no effect. If a timeout and a clear fall on the same edge, the timeout wins and the flag stays 1.
- R7: The watchdog ignores commands with `cmd_valid`=0, commands for another bank, and command codes other than 3'b101 and 3'b110.
- R8: An unlock with no lock outstanding changes nothing. A second lock while the bank is held does not restart the timer, so expiry is still counted from the first lock.
- R9: After a timeout, a late unlock leaves both outputs as they are. A new lock holds the bank again with a full LIMIT-cycle window.
- R10: After an unlock, the next lock gets a full LIMIT-cycle window. The internal count never exceeds LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_code | input | CMD_W | Command code (3'b101 lock read, 3'b110 unlock write) |
| cmd_bank | input | BANK_W | Target bank of the command |
| cfg_lock_to_dis | input | 1 | Suppress the timeout error flag |
| err_clr_we | input | 1 | Write strobe for the error flag |
| err_clr_bit | input | 1 | Write data; 1 clears the flag |
| bank_avail | output | 1 | Registered bank-available indication |
| lock_err | output | 1 | Registered sticky lock-timeout error |

## Verification
A wrong hold state shows up on `bank_avail` one edge after the command that should have changed it. Examples are a lock that is ignored, a second lock that restarts the timer, or an unlock that is lost. A miscounted timer shows up as `bank_avail` rising one edge early or late relative to edge LIMIT after the lock, and together with `lock_err` when the flag is enabled. A flag register with the wrong priority shows up on `lock_err` at the edge where a clear and an expiry coincide.

// File: rtl/blw_pkg.sv
package blw_pkg;
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_HELD    = 2'd1,
    LK_EXPIRED = 2'd2
  } lk_state_t;
endpackage

// File: rtl/blw_cmd_match.sv
module blw_cmd_match #(
  parameter int unsigned CMD_W   = 3,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned BANK_ID = 0,
  parameter logic [CMD_W-1:0] LOCK_CODE   = 3'b101,
  parameter logic [CMD_W-1:0] UNLOCK_CODE = 3'b110
) (
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              lock_hit,
  output logic              unlock_hit
);
  localparam logic [BANK_W-1:0] OWN_BANK = BANK_W'(BANK_ID);

  logic mine;

  always_comb begin
    mine       = cmd_valid && (cmd_bank == OWN_BANK);
    lock_hit   = mine && (cmd_code == LOCK_CODE);
    unlock_hit = mine && (cmd_code == UNLOCK_CODE);
  end
endmodule

// File: rtl/blw_timer.sv
module blw_timer #(
  parameter int unsigned LIMIT = 1024,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && (cnt < CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_last = (cnt == CNT_LAST);
endmodule

// File: rtl/blw_fsm.sv
module blw_fsm
  import blw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lock_hit,
  input  logic unlock_hit,
  input  logic at_last,
  output logic tmr_clear,
  output logic tmr_run,
  output logic timeout_evt,
  output logic bank_avail
);
  lk_state_t state, state_nx;
  logic      avail_nx;

  always_comb begin
    state_nx    = state;
    avail_nx    = bank_avail;
    tmr_clear   = 1'b0;
    tmr_run     = 1'b0;
    timeout_evt = 1'b0;
    unique case (state)
      LK_IDLE, LK_EXPIRED: begin
        if (lock_hit) begin
          state_nx  = LK_HELD;
          avail_nx  = 1'b0;
          tmr_clear = 1'b1;
        end else if (unlock_hit && (state == LK_EXPIRED)) begin
          state_nx  = LK_IDLE;
          tmr_clear = 1'b1;
        end
      end
      LK_HELD: begin
        if (unlock_hit) begin
          state_nx  = LK_IDLE;
          avail_nx  = 1'b1;
          tmr_clear = 1'b1;
        end else begin
          tmr_run = 1'b1;
          if (at_last) begin
            state_nx    = LK_EXPIRED;
            avail_nx    = 1'b1;
            timeout_evt = 1'b1;
          end
        end
      end
      default: begin
        state_nx  = LK_IDLE;
        avail_nx  = 1'b1;
        tmr_clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= LK_IDLE;
      bank_avail <= 1'b1;
    end else begin
      state      <= state_nx;
      bank_avail <= avail_nx;
    end
  end
endmodule

// File: rtl/blw_err_reg.sv
module blw_err_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic disable_set,
  input  logic clr_we,
  input  logic clr_bit,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else if (set_evt && !disable_set) begin
      err <= 1'b1;
    end else if (clr_we && clr_bit) begin
      err <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_lock_watchdog.sv
module bank_lock_watchdog #(
  parameter int unsigned CMD_W   = 3,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned BANK_ID = 0,
  parameter int unsigned LIMIT   = 1024,
  parameter logic [CMD_W-1:0] LOCK_CODE   = 3'b101,
  parameter logic [CMD_W-1:0] UNLOCK_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cfg_lock_to_dis,
  input  logic              err_clr_we,
  input  logic              err_clr_bit,
  output logic              bank_avail,
  output logic              lock_err
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic             lock_hit, unlock_hit;
  logic             tmr_clear, tmr_run, at_last, timeout_evt;
  logic [CNT_W-1:0] timer_cnt;

  blw_cmd_match #(
    .CMD_W(CMD_W), .BANK_W(BANK_W), .BANK_ID(BANK_ID),
    .LOCK_CODE(LOCK_CODE), .UNLOCK_CODE(UNLOCK_CODE)
  ) u_match (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .lock_hit  (lock_hit),
    .unlock_hit(unlock_hit)
  );

  blw_timer #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (tmr_clear),
    .run    (tmr_run),
    .cnt    (timer_cnt),
    .at_last(at_last)
  );

  blw_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .lock_hit   (lock_hit),
    .unlock_hit (unlock_hit),
    .at_last    (at_last),
    .tmr_clear  (tmr_clear),
    .tmr_run    (tmr_run),
    .timeout_evt(timeout_evt),
    .bank_avail (bank_avail)
  );

  blw_err_reg u_err (
    .clk        (clk),
    .rst        (rst),
    .set_evt    (timeout_evt),
    .disable_set(cfg_lock_to_dis),
    .clr_we     (err_clr_we),
    .clr_bit    (err_clr_bit),
    .err        (lock_err)
  );
endmodule

// File: rtl/bank_lock_watchdog_chk.sv
module bank_lock_watchdog_chk #(
  parameter int unsigned CMD_W   = 3,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned BANK_ID = 0,
  parameter int unsigned LIMIT   = 1024,
  parameter int unsigned CNT_W   = 11,
  parameter logic [CMD_W-1:0] LOCK_CODE   = 3'b101,
  parameter logic [CMD_W-1:0] UNLOCK_CODE = 3'b110
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              cfg_lock_to_dis,
  input logic              err_clr_we,
  input logic              err_clr_bit,
  input logic              bank_avail,
  input logic              lock_err,
  input logic [CNT_W-1:0]  timer_cnt
);
  logic lk_req, ul_req, clr_req;
  assign lk_req  = cmd_valid && (cmd_bank == BANK_W'(BANK_ID)) && (cmd_code == LOCK_CODE);
  assign ul_req  = cmd_valid && (cmd_bank == BANK_W'(BANK_ID)) && (cmd_code == UNLOCK_CODE);
  assign clr_req = err_clr_we && err_clr_bit;

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    bank_avail && lk_req |=> !bank_avail); // R2

  AST_UNLOCK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !bank_avail && ul_req && !clr_req |=> bank_avail && (lock_err == $past(lock_err))); // R3

  AST_ERR_WITH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_err) |-> $rose(bank_avail)); // R4

  AST_DIS_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    cfg_lock_to_dis && !lock_err |=> !lock_err); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bank_avail && clr_req |=> !lock_err); // R6

  AST_AVAIL_STAYS: assert property (@(posedge clk) disable iff (rst)
    bank_avail && !lk_req |=> bank_avail); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    timer_cnt <= CNT_W'(LIMIT)); // R10
endmodule

bind bank_lock_watchdog bank_lock_watchdog_chk #(
  .CMD_W(CMD_W), .BANK_W(BANK_W), .BANK_ID(BANK_ID), .LIMIT(LIMIT),
  .CNT_W(CNT_W), .LOCK_CODE(LOCK_CODE), .UNLOCK_CODE(UNLOCK_CODE)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .cfg_lock_to_dis(cfg_lock_to_dis),
  .err_clr_we(err_clr_we), .err_clr_bit(err_clr_bit),
  .bank_avail(bank_avail), .lock_err(lock_err), .timer_cnt(timer_cnt)
);

// File: tb/bank_lock_watchdog_tb.sv
module bank_lock_watchdog_tb;
  localparam int unsigned LIM  = 4;
  localparam int unsigned BID  = 5;
  localparam int          NVEC = 37;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [3:0] cmd_bank = '0;
  logic       cfg_lock_to_dis = 1'b0;
  logic       err_clr_we = 1'b0;
  logic       err_clr_bit = 1'b0;
  logic       bank_avail, lock_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bank_lock_watchdog #(.CMD_W(3), .BANK_W(4), .BANK_ID(BID), .LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cfg_lock_to_dis(cfg_lock_to_dis),
    .err_clr_we(err_clr_we), .err_clr_bit(err_clr_bit),
    .bank_avail(bank_avail), .lock_err(lock_err)
  );

  // valid | code | bank | dis | clr_we | clr_bit | exp_avail | exp_err
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0_000_0000_0_0_0_1_0, // 0  R1 idle
    13'b1_110_0101_0_0_0_1_0, // 1  R8 stray unlock
    13'b1_101_0011_0_0_0_1_0, // 2  R7 other bank
    13'b1_001_0101_0_0_0_1_0, // 3  R7 other code
    13'b0_101_0101_0_0_0_1_0, // 4  R7 not valid
    13'b1_101_0101_0_0_0_0_0, // 5  R2 lock
    13'b0_000_0000_0_0_0_0_0, // 6  R2
    13'b1_110_0011_0_0_0_0_0, // 7  R7 unlock other bank
    13'b1_110_0101_0_0_0_1_0, // 8  R3 unlock
    13'b1_101_0101_0_0_0_0_0, // 9  R10 relock
    13'b0_000_0000_0_0_0_0_0, // 10 R10
    13'b0_000_0000_0_0_0_0_0, // 11 R10
    13'b0_000_0000_0_0_0_0_0, // 12 R10
    13'b1_110_0101_0_0_0_1_0, // 13 R3 unlock at edge LIMIT
    13'b1_101_0101_0_0_0_0_0, // 14 R2
    13'b1_101_0101_0_0_0_0_0, // 15 R8 second lock
    13'b0_000_0000_0_0_0_0_0, // 16 R8
    13'b0_000_0000_0_0_0_0_0, // 17 R8
    13'b0_000_0000_0_0_0_1_1, // 18 R4 expiry
    13'b1_110_0101_0_0_0_1_1, // 19 R9 late unlock
    13'b0_000_0000_0_1_0_1_1, // 20 R6 write 0
    13'b0_000_0000_0_1_1_1_0, // 21 R6 write 1
    13'b1_101_0101_1_0_0_0_0, // 22 R5
    13'b0_000_0000_1_0_0_0_0, // 23 R5
    13'b0_000_0000_1_0_0_0_0, // 24 R5
    13'b0_000_0000_1_0_0_0_0, // 25 R5
    13'b0_000_0000_1_0_0_1_0, // 26 R5 release without flag
    13'b1_101_0101_0_0_0_0_0, // 27 R2
    13'b0_000_0000_0_0_0_0_0, // 28 R4
    13'b0_000_0000_0_0_0_0_0, // 29 R4
    13'b0_000_0000_0_0_0_0_0, // 30 R4
    13'b0_000_0000_0_1_1_1_1, // 31 R6 set beats clear
    13'b1_101_0101_0_0_0_0_1, // 32 R9 relock after expiry
    13'b0_000_0000_0_0_0_0_1, // 33 R9
    13'b0_000_0000_0_0_0_0_1, // 34 R9
    13'b0_000_0000_0_0_0_0_1, // 35 R9
    13'b1_110_0101_0_0_0_1_1  // 36 R9 full window
  };
  localparam int VREQ [NVEC] = '{1,8,7,7,7,2,2,7,3,10,10,10,10,3,2,8,8,8,4,9,
                                 6,6,5,5,5,5,5,2,4,4,4,6,9,9,9,9,9};

  task automatic check(input int req, input logic ea, input logic ee, input int tag);
    n_checks++;
    if (bank_avail !== ea || lock_err !== ee) begin
      n_fail++;
      $display("FAIL R%0d step %0d: avail=%b err=%b expected avail=%b err=%b",
               req, tag, bank_avail, lock_err, ea, ee);
    end
  endtask

  task automatic drive(input logic [12:0] v);
    cmd_valid       = v[12];
    cmd_code        = v[11:9];
    cmd_bank        = v[8:5];
    cfg_lock_to_dis = v[4];
    err_clr_we      = v[3];
    err_clr_bit     = v[2];
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  localparam logic [12:0] NOP  = 13'b0_000_0000_0_0_0_0_0;
  localparam logic [12:0] LOCK = 13'b1_101_0101_0_0_0_0_0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1, 1'b1, 1'b0, -1); // R1 reset state
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      step();
      check(VREQ[i], VEC[i][1], VEC[i][0], i);
    end
    // R4: bank held through edge LIMIT-1, released at edge LIMIT
    drive(LOCK); step();
    drive(NOP);
    for (int k = 1; k < int'(LIM); k++) begin
      step();
      check(4, 1'b0, 1'b1, 100 + k);
    end
    step();
    check(4, 1'b1, 1'b1, 100 + int'(LIM));
    // R1: reset while the bank is held
    drive(LOCK); step();
    check(2, 1'b0, 1'b1, 200);
    drive(NOP);
    rst = 1'b1; step();
    rst = 1'b0;
    check(1, 1'b1, 1'b0, 201);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule